// File: doc/BRIEF.md
# Pulse-Gap Carrier Downlink Modulator

This block turns an already assembled downlink frame into the on/off pattern of a low-frequency reader field. One output, `carrier_en`, gates the carrier. Each symbol is sent as a field-on interval whose length carries the value, and a fixed field-off gap follows it. All durations are counted in carrier cycles, and the carrier cycles are marked by a one-clock `tick` input (one pulse per carrier period, 8 µs at 125 kHz). A frame is taken on a `start` pulse. The block raises `busy` until the sequence ends, then pulses `done`. If asked, it turns the field back on for a short read gap before it finishes, so that the tag reply can then be acquired.

There are four downlink modes, selected by the 2-bit `mode` input: 0 fixed-bit, 1 long-reference, 2 leading-zero, 3 one-of-four. They differ in their on-time table. Long-reference mode also sends one extended reference pulse. One-of-four mode sends the frame as dibits, using four pulse lengths. Frame bit 0 is sent first.

The controller is a single state machine with these states:
- `ST_IDLE` (field off, waiting).
- `ST_START_GAP` (field off for the start gap).
- `ST_REF_ON` (reference pulse on).
- `ST_SYM_ON` (symbol on-time).
- `ST_WRITE_GAP` (field off after a pulse).
- `ST_READ_GAP` (field on before acquisition).

Its transitions are:
- IDLE→START_GAP when `start` is seen.
- START_GAP→REF_ON in long-reference mode.
- START_GAP or WRITE_GAP→SYM_ON while symbols remain.
- REF_ON or SYM_ON→WRITE_GAP when the on-time expires.
- START_GAP or WRITE_GAP→READ_GAP when no symbols remain and a read gap was requested.
- START_GAP, WRITE_GAP or READ_GAP→IDLE when the sequence ends. This transition raises `done`.

Top module: `pgap_downlink_mod`

## Requirements
- R1: After reset, `carrier_en`, `busy` and `done` are all 0.
- R2: A sequence begins with `carrier_en` low for 31 ticks. Every pulse (reference or symbol) is followed by `carrier_en` low for 20 ticks.
- R3: In modes 0 (fixed-bit) and 1 (long-reference), a 0 bit is high for 18 ticks and a 1 bit is high for 50 ticks. Frame bit 0 is sent first.
- R4: In mode 2 (leading-zero), a 1 bit is high for 40 ticks and a 0 bit is high for 18 ticks.
- R5: In mode 3 (one-of-four), bits are paired in frame order, and the earlier bit is the MSB of the dibit. On-times are 18, 34, 50 and 66 ticks for dibits 00, 01, 10 and 11.
- R6: In mode 3, the last bit of an odd-length frame is not sent.
- R7: In mode 1, a reference pulse high for 154 ticks (the zero on-time plus 136) follows the start gap, and a normal 20-tick gap follows the pulse.
- R8: When `read_hold` is 1 at start, `carrier_en` goes high for 15 ticks after the last gap, before the sequence ends.
- R9: `busy` is 1 from the cycle after `start` is taken until the sequence ends. `done` is 1 for exactly one clock, in the first cycle with `busy` low.
- R10: A `start` while `busy` is 1 is ignored: the current sequence and its captured inputs do not change.
- R11: A frame length of 0 produces only the start gap (plus the reference pulse and its gap in mode 1, and the read gap if requested).
- R12: Intervals advance only on `tick`. While `tick` stays low, `carrier_en` holds its value.
- R13: A `frame_len` above MAX_BITS (80) is treated as MAX_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock pulse per carrier cycle |
| start | input | 1 | Begin a sequence (taken only when idle) |
| frame | input | 80 | Frame bits, bit 0 sent first |
| frame_len | input | 7 | Number of valid frame bits |
| mode | input | 2 | 0 fixed-bit, 1 long-reference, 2 leading-zero, 3 one-of-four |
| read_hold | input | 1 | Add a field-on read gap after the frame |
| carrier_en | output | 1 | Carrier field enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock end-of-sequence pulse |

## Verification
Two functions can meet in one cycle: the end of a sequence (`done` high, state back to idle) and the acceptance of a new `start`. The bench holds `start` high through the whole first sequence while it presents a different frame and mode on the inputs. Throughout that sequence the request must be refused, and the first frame's pulse pattern must come out unchanged. In the very cycle that `done` appears, the same held request must be taken, so `busy` is high again one clock later and the second frame's pattern follows exactly.

// File: rtl/pgap_pkg.sv
package pgap_pkg;

    typedef enum logic [1:0] {
        DL_FIXED    = 2'd0,
        DL_LONGREF  = 2'd1,
        DL_LEADZERO = 2'd2,
        DL_DIBIT    = 2'd3
    } dl_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_GAP,
        ST_REF_ON,
        ST_SYM_ON,
        ST_WRITE_GAP,
        ST_READ_GAP
    } pg_state_e;

    function automatic int pgap_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pgap_ontime.sv
// Selects the field-on duration of the next pulse from mode and bit values.
module pgap_ontime
    import pgap_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int T_ZERO      = 18,
    parameter int T_ONE       = 50,
    parameter int T_ONE_LZ    = 40,
    parameter int T_D01       = 34,
    parameter int T_D10       = 50,
    parameter int T_D11       = 66,
    parameter int T_REF_EXTRA = 136
) (
    input  dl_mode_e         mode,
    input  logic             first_bit,
    input  logic             second_bit,
    input  logic             pick_ref,
    output logic [CNT_W-1:0] on_len
);

    always_comb begin
        on_len = CNT_W'(T_ZERO);
        if (pick_ref) begin
            on_len = CNT_W'(T_ZERO + T_REF_EXTRA);
        end else begin
            unique case (mode)
                DL_DIBIT: begin
                    unique case ({first_bit, second_bit})
                        2'b00: on_len = CNT_W'(T_ZERO);
                        2'b01: on_len = CNT_W'(T_D01);
                        2'b10: on_len = CNT_W'(T_D10);
                        2'b11: on_len = CNT_W'(T_D11);
                        default: on_len = CNT_W'(T_ZERO);
                    endcase
                end
                DL_LEADZERO: on_len = first_bit ? CNT_W'(T_ONE_LZ) : CNT_W'(T_ZERO);
                default:     on_len = first_bit ? CNT_W'(T_ONE) : CNT_W'(T_ZERO);
            endcase
        end
    end

endmodule

// File: rtl/pgap_interval.sv
// Down-counter of carrier ticks; flags the tick that ends the interval.
module pgap_interval #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = tick && (cnt_q == CNT_W'(1));

    // R2: every interval loaded is at least one tick long
    a_r2_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

    // R12: without a tick the count holds
    a_r12_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/pgap_downlink_mod.sv
module pgap_downlink_mod
    import pgap_pkg::*;
#(
    parameter int MAX_BITS    = 80,
    parameter int T_START     = 31,
    parameter int T_WGAP      = 20,
    parameter int T_ZERO      = 18,
    parameter int T_ONE       = 50,
    parameter int T_ONE_LZ    = 40,
    parameter int T_D01       = 34,
    parameter int T_D10       = 50,
    parameter int T_D11       = 66,
    parameter int T_REF_EXTRA = 136,
    parameter int T_READ      = 15,
    localparam int LEN_W      = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                start,
    input  logic [MAX_BITS-1:0] frame,
    input  logic [LEN_W-1:0]    frame_len,
    input  logic [1:0]          mode,
    input  logic                read_hold,
    output logic                carrier_en,
    output logic                busy,
    output logic                done
);

    localparam int LONGEST = pgap_max(pgap_max(pgap_max(T_START, T_WGAP),
                                               pgap_max(T_ZERO + T_REF_EXTRA, T_READ)),
                                      pgap_max(pgap_max(T_ONE, T_ONE_LZ),
                                               pgap_max(T_D01, pgap_max(T_D10, T_D11))));
    localparam int CNT_W = $clog2(LONGEST + 1);

    pg_state_e           state_q, state_d;
    logic [MAX_BITS-1:0] frame_q;
    logic [LEN_W-1:0]    rem_q;
    dl_mode_e            mode_q;
    logic                hold_q;
    logic                done_q;

    logic                load;
    logic [CNT_W-1:0]    load_val;
    logic                expire;
    logic [CNT_W-1:0]    on_len;
    logic                pick_ref;
    logic                accept;
    logic                shift;
    logic                finish;
    logic                more;
    logic [LEN_W-1:0]    step;
    logic [LEN_W-1:0]    len_clamped;

    assign pick_ref    = (state_q == ST_START_GAP) && (mode_q == DL_LONGREF);
    assign step        = (mode_q == DL_DIBIT) ? LEN_W'(2) : LEN_W'(1);
    assign more        = (mode_q == DL_DIBIT) ? (rem_q >= LEN_W'(2)) : (rem_q != '0);
    assign len_clamped = (frame_len > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : frame_len;

    pgap_ontime #(
        .CNT_W(CNT_W), .T_ZERO(T_ZERO), .T_ONE(T_ONE), .T_ONE_LZ(T_ONE_LZ),
        .T_D01(T_D01), .T_D10(T_D10), .T_D11(T_D11), .T_REF_EXTRA(T_REF_EXTRA)
    ) u_ontime (
        .mode      (mode_q),
        .first_bit (frame_q[0]),
        .second_bit(frame_q[1]),
        .pick_ref  (pick_ref),
        .on_len    (on_len)
    );

    pgap_interval #(.CNT_W(CNT_W)) u_interval (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (load),
        .load_val(load_val),
        .expire  (expire)
    );

    // Next-state and interval-load decisions
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        shift    = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    accept   = 1'b1;
                    state_d  = ST_START_GAP;
                    load     = 1'b1;
                    load_val = CNT_W'(T_START);
                end
            end
            ST_START_GAP, ST_WRITE_GAP: begin
                if (expire) begin
                    if (pick_ref || more) begin
                        state_d  = pick_ref ? ST_REF_ON : ST_SYM_ON;
                        load     = 1'b1;
                        load_val = on_len;
                    end else if (hold_q) begin
                        state_d  = ST_READ_GAP;
                        load     = 1'b1;
                        load_val = CNT_W'(T_READ);
                    end else begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end
                end
            end
            ST_REF_ON, ST_SYM_ON: begin
                if (expire) begin
                    state_d  = ST_WRITE_GAP;
                    load     = 1'b1;
                    load_val = CNT_W'(T_WGAP);
                    shift    = (state_q == ST_SYM_ON);
                end
            end
            ST_READ_GAP: begin
                if (expire) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and captured-frame registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            frame_q <= '0;
            rem_q   <= '0;
            mode_q  <= DL_FIXED;
            hold_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (accept) begin
                frame_q <= frame;
                rem_q   <= len_clamped;
                mode_q  <= dl_mode_e'(mode);
                hold_q  <= read_hold;
            end else if (shift) begin
                frame_q <= (mode_q == DL_DIBIT) ? (frame_q >> 2) : (frame_q >> 1);
                rem_q   <= rem_q - step;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        carrier_en = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE:                          busy       = 1'b0;
            ST_REF_ON, ST_SYM_ON, ST_READ_GAP: carrier_en = 1'b1;
            default:                          carrier_en = 1'b0;
        endcase
        done = done_q;
    end

    // R9: done comes right after busy falls
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R10: captured mode and read request stay put while busy
    a_r10_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || ($stable(mode_q) && $stable(hold_q))));

    // R12: the field only toggles on a carrier tick while busy
    a_r12_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(carrier_en));

    // R6: a dibit symbol always has two bits left
    a_r6_dibit_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYM_ON && mode_q == DL_DIBIT) |-> (rem_q >= LEN_W'(2)));

    // R7: the reference pulse appears only in long-reference mode
    a_r7_ref_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REF_ON) |-> (mode_q == DL_LONGREF));

    // R8: read gap only when requested
    a_r8_read_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ_GAP) |-> hold_q);

endmodule

// File: tb/sim_pgap_downlink_mod.sv
module sim_pgap_downlink_mod;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic [79:0] frame = '0;
    logic [6:0]  frame_len = '0;
    logic [1:0]  mode = '0;
    logic        read_hold = 1'b0;
    logic        carrier_en, busy, done;

    int n_chk = 0;
    int n_fail = 0;

    pgap_downlink_mod u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .frame(frame),
        .frame_len(frame_len), .mode(mode), .read_hold(read_hold),
        .carrier_en(carrier_en), .busy(busy), .done(done)
    );

    always #5 clk = ~clk;

    // carrier tick generator
    bit tick_en = 1'b1;
    int tcnt = 0;
    always @(posedge clk) begin
        if (!tick_en) begin
            tick <= 1'b0;
        end else if (tcnt >= 1) begin
            tick <= 1'b1;
            tcnt <= 0;
        end else begin
            tick <= 1'b0;
            tcnt <= tcnt + 1;
        end
    end

    // segment recorder: run lengths of carrier_en measured in ticks while busy
    int seg_lvl [0:4095];
    int seg_len [0:4095];
    int nseg = 0;
    int base = 0;
    always @(negedge clk) begin
        if (rst_n && busy && tick) begin
            if (nseg == base) begin
                seg_lvl[nseg] = int'(carrier_en); seg_len[nseg] = 1; nseg++;
            end else if (seg_lvl[nseg-1] != int'(carrier_en)) begin
                seg_lvl[nseg] = int'(carrier_en); seg_len[nseg] = 1; nseg++;
            end else begin
                seg_len[nseg-1]++;
            end
        end
    end

    int exp_lvl [0:255];
    int exp_len [0:255];
    int nexp = 0;

    task automatic chk(input bit ok, input string req, input int got, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    task automatic add(input int lvl, input int len);
        exp_lvl[nexp] = lvl; exp_len[nexp] = len; nexp++;
    endtask

    task automatic build_exp(input logic [79:0] f, input int len, input int md, input bit hold);
        int n;
        n = (len > 80) ? 80 : len;
        nexp = 0;
        add(0, 31);
        if (md == 1) begin add(1, 154); add(0, 20); end
        if (md == 3) begin
            for (int i = 0; i + 1 < n; i += 2) begin
                int v;
                v = int'(f[i]) * 2 + int'(f[i+1]);
                add(1, (v == 0) ? 18 : (v == 1) ? 34 : (v == 2) ? 50 : 66);
                add(0, 20);
            end
        end else begin
            for (int i = 0; i < n; i++) begin
                add(1, f[i] ? ((md == 2) ? 40 : 50) : 18);
                add(0, 20);
            end
        end
        if (hold) add(1, 15);
    endtask

    // compare recorded pattern (level*1000+ticks) with expectation
    task automatic compare_run(input string req);
        int got;
        int bad;
        got = nseg - base;
        bad = -1;
        if (got != nexp) begin
            chk(1'b0, {req, " segment count"}, got, nexp);
        end else begin
            for (int i = 0; i < nexp; i++) begin
                if (bad < 0 && (seg_lvl[base+i] != exp_lvl[i] || seg_len[base+i] != exp_len[i]))
                    bad = i;
            end
            if (bad >= 0)
                chk(1'b0, {req, " pattern"}, seg_lvl[base+bad]*1000 + seg_len[base+bad],
                    exp_lvl[bad]*1000 + exp_len[bad]);
            else
                chk(1'b1, req, 0, 0);
        end
    endtask

    task automatic wait_done(output bit timed_out);
        int k;
        k = 0;
        while (!done && k < 40000) begin @(negedge clk); k++; end
        timed_out = (k >= 40000);
    endtask

    // opt: 0 plain, 1 tick stall mid-run, 2 start while busy
    task automatic run(input logic [79:0] f, input int len, input int md, input bit hold,
                       input int opt, input string req);
        bit to;
        build_exp(f, len, md, hold);
        @(negedge clk);
        frame = f; frame_len = 7'(len); mode = 2'(md); read_hold = hold;
        base = nseg;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
        if (opt == 1) begin
            logic lvl;
            bit ok;
            repeat (100) @(negedge clk);
            tick_en = 1'b0;
            repeat (3) @(negedge clk);
            lvl = carrier_en;
            ok = 1'b1;
            repeat (40) begin
                @(negedge clk);
                if (carrier_en != lvl) ok = 1'b0;
            end
            tick_en = 1'b1;
            chk(ok, "R12 hold without tick", int'(carrier_en), int'(lvl));
        end
        if (opt == 2) begin
            repeat (150) @(negedge clk);
            frame = ~f; frame_len = 7'd3; mode = 2'(md) ^ 2'd1; read_hold = ~hold;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(to);
        if (to) begin
            chk(1'b0, {req, " timeout"}, 0, 1);
        end else begin
            chk(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
            compare_run(req);
            @(negedge clk);
            chk(done == 1'b0, "R9 done one clock", int'(done), 0);
        end
    endtask

    // start held high through a whole run: refused while busy, taken in the done cycle
    task automatic test_b2b();
        bit to;
        logic [79:0] fa, fb;
        fa = 80'h5A;
        fb = 80'hC9;
        build_exp(fa, 6, 0, 1'b0);
        @(negedge clk);
        frame = fa; frame_len = 7'd6; mode = 2'd0; read_hold = 1'b0;
        base = nseg;
        start = 1'b1;
        @(negedge clk);
        frame = fb; frame_len = 7'd8; mode = 2'd3; read_hold = 1'b1;
        wait_done(to);
        if (to) begin
            chk(1'b0, "R10 b2b timeout", 0, 1);
        end else begin
            compare_run("R10 held start ignored");
            base = nseg;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R9 start taken in done cycle", int'(busy), 1);
            build_exp(fb, 8, 3, 1'b1);
            wait_done(to);
            if (to) chk(1'b0, "R9 b2b second timeout", 0, 1);
            else compare_run("R9 second run after coincident start");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        n_fail++;
        n_chk++;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(carrier_en == 1'b0, "R1 carrier_en reset", int'(carrier_en), 0);
        chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
        chk(done == 1'b0, "R1 done reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run(80'hB2, 8, 0, 1'b0, 0, "R2 R3 fixed-bit frame");
        run(80'h0D, 5, 1, 1'b0, 0, "R7 R3 long-reference frame");
        run(80'hB2, 8, 2, 1'b0, 0, "R4 leading-zero frame");
        run(80'hD8, 8, 3, 1'b0, 0, "R5 one-of-four all dibits");
        run(80'h6D, 7, 3, 1'b0, 0, "R6 one-of-four odd length");
        run(80'h1, 1, 3, 1'b0, 0, "R6 one-of-four single bit");
        run(80'hFF, 0, 0, 1'b0, 0, "R11 empty fixed frame");
        run(80'hFF, 0, 1, 1'b1, 0, "R11 R8 empty long-reference frame");
        run(80'h3C, 6, 2, 1'b1, 0, "R8 read gap after frame");
        run(80'hA5, 8, 0, 1'b0, 2, "R10 start while busy");
        run(80'h96, 8, 3, 1'b0, 1, "R12 stalled ticks");
        run({80{1'b1}} ^ 80'h5, 100, 0, 1'b0, 0, "R13 length clamped");
        test_b2b();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule